// File: doc/BRIEF.md
# Prioritized Core Event Controller

This block arbitrates sixteen numbered event levels for a processor core. Level 0 has the highest priority and level 15 the lowest. Event requests arrive as single-cycle pulses and are held in a latched-request register. The block masks them and compares the most urgent one against the level the core is running at now. When a level wins, the block records it as active and produces a one-cycle take strobe together with the handler address. Active levels are kept as a bit vector, so nested handlers stack up in that register. One bit of that vector, at level 4, acts as a global disable for the maskable levels.

Level 0 is emulation, 1 is reset, 2 is the non-maskable interrupt, 3 is the exception level, 4 is the global-disable bit, 5 is hardware error, 6 is the core timer, and 7 to 15 are general-purpose. Software uses five 32-bit registers to redirect vectors, set the mask, observe active levels, clear latched requests and hold priority bits. The pipeline leaves a handler by presenting a return request. That request carries the kind of return and the saved return address, and the block then either unwinds the active level or reports an illegal return.

Top module: `evt_ctrl`

## Requirements
- R1: After reset the mask register reads 0x0000000F, the active register reads 0x00000012 (reset level plus global-disable), override, latched and priority read 0, cur_level is 1 and super_mode is 1.
- R2: Register byte offsets are 0x00 override, 0x04 mask, 0x08 active, 0x0C latched and 0x10 priority. Bits 31:16 read 0, and any other offset reads 0 and ignores writes. The override register stores the low 16 written bits.
- R3: A mask write stores (data & 0xFFE0) | 0x000F. A priority write stores data & 0x000F. A write to the active register changes nothing.
- R4: Each request pulse ORs its level into the latched register. Writing a 1 to a latched bit clears it, but a request for that bit in the same cycle keeps it set.
- R5: cur_level is the lowest set bit of the active register excluding bits 0 and 4, or 16 when none is set (user mode). super_mode is 1 exactly when cur_level is below 16.
- R6: In each cycle without a register write or return request, the candidate is the lowest set bit of latched AND mask. A candidate of 5 or more is taken only if the global-disable bit is clear and the candidate is below cur_level, or equal to it with nest_en high. Level 4 is never taken.
- R7: Candidates 0 and 1 are always taken, even with global-disable set. A candidate 2 or 3 is taken if it is below cur_level. Otherwise dbl_fault pulses for one cycle, its latched bit is cleared and nothing is taken.
- R8: Taking a level sets its active bit, clears its latched bit and, for levels 5 and above, sets the global-disable bit. pc_take pulses in the cycle after the arbitration cycle.
- R9: The taken handler address is rst_vec when the level is 7 or above and its override bit is set. Otherwise it is that level's entry of vec_tbl (bits l*32+31 to l*32).
- R10: A valid return clears the returned level's active bit unless ret_addr bit 0 is 1. It clears global-disable when the level is 1 or 5 and above. It pulses pc_take with pc_new = ret_addr with bit 0 cleared. Kind encoding: 0 general (returns from cur_level), 1 emulation (level 0), 2 NMI (level 2), 3 exception (level 3).
- R11: An emulation return is valid only with active bit 0 set. An NMI return is valid only at cur_level 2 and an exception return only at cur_level 3. A general return is invalid at cur_level 2, 3 or 16. An invalid return pulses ill_ret, leaves the active register unchanged and latches level 3.
- R12: Arbitration is skipped in cycles with a register write or a return request and resumes on the next cycle. When several requests are latched together, the lowest-numbered level wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write enable for the access |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| evt_req | input | 16 | Single-cycle request pulse per level |
| ret_valid | input | 1 | Return request strobe |
| ret_kind | input | 2 | Return kind (0 general, 1 emulation, 2 NMI, 3 exception) |
| ret_addr | input | 32 | Saved return address, bit 0 marks self-nesting |
| nest_en | input | 1 | Allows a level to preempt itself |
| vec_tbl | input | 512 | Sixteen 32-bit handler addresses |
| rst_vec | input | 32 | Reset handler address used by overridden levels |
| cur_level | output | 5 | Current level, 16 for user mode |
| super_mode | output | 1 | Any active level other than 0 and 4 |
| dbl_fault | output | 1 | One-cycle double-fault pulse |
| ill_ret | output | 1 | One-cycle illegal-return pulse |
| pc_take | output | 1 | One-cycle strobe: pc_new is valid |
| pc_new | output | 32 | Handler or return address |

## Verification
The bench targets the global-disable bit. A design that ignored it would nest a second maskable handler at once, and one that honoured it for levels 0 to 3 would never let reset or emulation preempt. It also covers the self-nesting return with bit 0 set. A wrong design there would drop the active bit, or fail to re-enter the same level with nesting enabled. Other targets are double faults on a repeated exception, the latched exception that an illegal return leaves behind, and the W1C write racing a new request. A wrong latched-register update would lose that request. Simultaneous requests and vector override round this out: a wrong priority encoder would pick the wrong level, and a wrong override decode would send a general-purpose level to its own vector.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int NLVL    = 16;
    localparam int LIDX    = $clog2(NLVL);
    localparam int LW      = $clog2(NLVL + 1);
    localparam int PC_W    = 32;
    localparam int REG_W   = 32;

    localparam int LV_EMU  = 0;
    localparam int LV_RST  = 1;
    localparam int LV_NMI  = 2;
    localparam int LV_EXC  = 3;
    localparam int LV_GD   = 4;
    localparam int LV_HWE  = 5;
    localparam int LV_GP   = 7;
    localparam int LV_USER = NLVL;

    localparam logic [NLVL-1:0] FIXED_ON   = 16'h000F;
    localparam logic [NLVL-1:0] MASKABLE   = 16'hFFE0;
    localparam logic [NLVL-1:0] CUR_SKIP   = 16'h0011;
    localparam logic [NLVL-1:0] ACTIVE_RST = 16'h0012;

    typedef enum logic [1:0] {
        RET_GEN = 2'd0,
        RET_EMU = 2'd1,
        RET_NMI = 2'd2,
        RET_EXC = 2'd3
    } ret_kind_e;

    typedef struct packed {
        logic [NLVL-1:0] ovr;
        logic [NLVL-1:0] mask;
        logic [NLVL-1:0] pend;
        logic [NLVL-1:0] lat;
        logic [NLVL-1:0] prio;
        logic            take;
        logic            dbl;
        logic            ill;
        logic [PC_W-1:0] pc;
    } evt_state_t;

    localparam evt_state_t ST_RST = '{
        ovr:  '0,
        mask: FIXED_ON,
        pend: ACTIVE_RST,
        lat:  '0,
        prio: '0,
        take: 1'b0,
        dbl:  1'b0,
        ill:  1'b0,
        pc:   '0
    };
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
    parameter int W  = 16,
    parameter int OW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [OW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = OW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = OW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_vec_sel.sv
module evt_vec_sel #(
    parameter int NL     = 16,
    parameter int PW     = 32,
    parameter int IW     = $clog2(NL),
    parameter int GP_MIN = 7
) (
    input  logic [IW-1:0]    lvl,
    input  logic [NL-1:0]    ovr,
    input  logic [NL*PW-1:0] vec_tbl,
    input  logic [PW-1:0]    rst_vec,
    output logic [PW-1:0]    pc
);
    logic [PW-1:0] tbl [NL];

    for (genvar g = 0; g < NL; g++) begin : g_tbl
        assign tbl[g] = vec_tbl[g*PW +: PW];
    end

    assign pc = ((int'(lvl) >= GP_MIN) && ovr[lvl]) ? rst_vec : tbl[lvl];
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
    import evt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NLVL-1:0]      evt_req,
    input  logic                 ret_valid,
    input  logic [1:0]           ret_kind,
    input  logic [PC_W-1:0]      ret_addr,
    input  logic                 nest_en,
    input  logic [NLVL*PC_W-1:0] vec_tbl,
    input  logic [PC_W-1:0]      rst_vec,
    output logic [LW-1:0]        cur_level,
    output logic                 super_mode,
    output logic                 dbl_fault,
    output logic                 ill_ret,
    output logic                 pc_take,
    output logic [PC_W-1:0]      pc_new
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam int PAD_W  = REG_W - NLVL;

    evt_state_t st_d, st_q;

    logic [LW-1:0]     cur_lvl, cand_lvl, ret_lvl;
    logic              cur_found, cand_found;
    logic [PC_W-1:0]   vec_pc;
    logic [NLVL-1:0]   lat_clr, lat_set;
    logic              take_go, ret_ok, wr;
    logic [WIDX_W-1:0] widx;
    logic              unused_bits;

    assign wr          = reg_en & reg_we;
    assign widx        = reg_addr[ADDR_W-1:2];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[REG_W-1:NLVL]};

    evt_prio_enc #(.W(NLVL), .OW(LW)) u_cur (
        .vec   (st_q.pend & ~CUR_SKIP),
        .idx   (cur_lvl),
        .found (cur_found)
    );

    evt_prio_enc #(.W(NLVL), .OW(LW)) u_cand (
        .vec   (st_q.lat & st_q.mask),
        .idx   (cand_lvl),
        .found (cand_found)
    );

    evt_vec_sel #(.NL(NLVL), .PW(PC_W), .IW(LIDX), .GP_MIN(LV_GP)) u_vec (
        .lvl     (cand_lvl[LIDX-1:0]),
        .ovr     (st_q.ovr),
        .vec_tbl (vec_tbl),
        .rst_vec (rst_vec),
        .pc      (vec_pc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.dbl  = 1'b0;
        st_d.ill  = 1'b0;
        lat_clr   = '0;
        lat_set   = '0;
        take_go   = 1'b0;
        ret_lvl   = cur_lvl;
        ret_ok    = 1'b0;

        case (ret_kind)
            RET_EMU: begin
                ret_lvl = LW'(LV_EMU);
                ret_ok  = st_q.pend[LV_EMU];
            end
            RET_NMI: begin
                ret_lvl = LW'(LV_NMI);
                ret_ok  = (int'(cur_lvl) == LV_NMI);
            end
            RET_EXC: begin
                ret_lvl = LW'(LV_EXC);
                ret_ok  = (int'(cur_lvl) == LV_EXC);
            end
            default: begin
                ret_lvl = cur_lvl;
                ret_ok  = cur_found && (int'(cur_lvl) != LV_NMI) &&
                          (int'(cur_lvl) != LV_EXC);
            end
        endcase

        if (ret_valid) begin
            if (ret_ok) begin
                if (!ret_addr[0]) begin
                    st_d.pend[ret_lvl[LIDX-1:0]] = 1'b0;
                end
                if (int'(ret_lvl) >= LV_HWE || int'(ret_lvl) == LV_RST) begin
                    st_d.pend[LV_GD] = 1'b0;
                end
                st_d.take = 1'b1;
                st_d.pc   = {ret_addr[PC_W-1:1], 1'b0};
            end else begin
                st_d.ill        = 1'b1;
                lat_set[LV_EXC] = 1'b1;
            end
        end else if (!wr && cand_found) begin
            if (int'(cand_lvl) <= LV_RST) begin
                take_go = 1'b1;
            end else if (int'(cand_lvl) <= LV_EXC) begin
                if (cur_lvl <= cand_lvl) begin
                    st_d.dbl                      = 1'b1;
                    lat_clr[cand_lvl[LIDX-1:0]]   = 1'b1;
                end else begin
                    take_go = 1'b1;
                end
            end else if (int'(cand_lvl) >= LV_HWE) begin
                take_go = !st_q.pend[LV_GD] &&
                          ((cand_lvl < cur_lvl) || (nest_en && cand_lvl == cur_lvl));
            end
        end

        if (take_go) begin
            st_d.pend[cand_lvl[LIDX-1:0]] = 1'b1;
            lat_clr[cand_lvl[LIDX-1:0]]   = 1'b1;
            if (int'(cand_lvl) >= LV_HWE) begin
                st_d.pend[LV_GD] = 1'b1;
            end
            st_d.take = 1'b1;
            st_d.pc   = vec_pc;
        end

        if (wr) begin
            case (int'(widx))
                0: st_d.ovr  = reg_wdata[NLVL-1:0];
                1: st_d.mask = (reg_wdata[NLVL-1:0] & MASKABLE) | FIXED_ON;
                3: lat_clr   = lat_clr | reg_wdata[NLVL-1:0];
                4: st_d.prio = reg_wdata[NLVL-1:0] & FIXED_ON;
                default: ;
            endcase
        end

        st_d.lat = (st_q.lat & ~lat_clr) | evt_req | lat_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (int'(widx))
            0:       reg_rdata = {{PAD_W{1'b0}}, st_q.ovr};
            1:       reg_rdata = {{PAD_W{1'b0}}, st_q.mask};
            2:       reg_rdata = {{PAD_W{1'b0}}, st_q.pend};
            3:       reg_rdata = {{PAD_W{1'b0}}, st_q.lat};
            4:       reg_rdata = {{PAD_W{1'b0}}, st_q.prio};
            default: reg_rdata = '0;
        endcase
    end

    assign cur_level  = cur_lvl;
    assign super_mode = cur_found;
    assign dbl_fault  = st_q.dbl;
    assign ill_ret    = st_q.ill;
    assign pc_take    = st_q.take;
    assign pc_new     = st_q.pc;
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk
    import evt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              ret_valid,
    input logic [LW-1:0]     cur_level,
    input logic              super_mode,
    input logic              dbl_fault,
    input logic              ill_ret,
    input logic              pc_take,
    input logic [NLVL-1:0]   pend_q,
    input logic [NLVL-1:0]   mask_q
);
    // R3: unmaskable bits stay set and bit 4 never enters the mask
    a_r3_mask_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[3:0] == 4'hF) && !mask_q[LV_GD]);

    // R3: a write to the active register leaves it unchanged
    a_r3_active_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && int'(reg_addr) == 8 && !ret_valid) |=> $stable(pend_q));

    // R11: an illegal return leaves the active register as it was
    a_r11_ill_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        ill_ret |-> (pend_q == $past(pend_q)));

    // R8: take, double fault and illegal return never pulse together
    a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_take, dbl_fault, ill_ret}));

    // R5: user mode and supervisor mode are exclusive
    a_r5_user_not_super: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur_level) == LV_USER) |-> !super_mode);

    // R5: supervisor mode implies a real level
    a_r5_super_has_level: assert property (@(posedge clk) disable iff (!rst_n)
        super_mode |-> (int'(cur_level) < LV_USER));
endmodule

bind evt_ctrl evt_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .ret_valid  (ret_valid),
    .cur_level  (cur_level),
    .super_mode (super_mode),
    .dbl_fault  (dbl_fault),
    .ill_ret    (ill_ret),
    .pc_take    (pc_take),
    .pend_q     (st_q.pend),
    .mask_q     (st_q.mask)
);

// File: tb/evt_ctrl_tb.sv
module evt_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_en = 1'b0, reg_we = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0, reg_rdata;
    logic [15:0]  evt_req = '0;
    logic         ret_valid = 1'b0;
    logic [1:0]   ret_kind = '0;
    logic [31:0]  ret_addr = '0;
    logic         nest_en = 1'b0;
    logic [511:0] vec_tbl;
    logic [31:0]  rst_vec = 32'hFFA0_0000;
    logic [4:0]   cur_level;
    logic         super_mode, dbl_fault, ill_ret, pc_take;
    logic [31:0]  pc_new;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    logic [15:0] m_ovr, m_mask, m_pend, m_lat, m_prio;
    logic [31:0] m_pc;
    bit          m_take, m_dbl, m_ill;

    evt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_req(evt_req), .ret_valid(ret_valid), .ret_kind(ret_kind),
        .ret_addr(ret_addr), .nest_en(nest_en), .vec_tbl(vec_tbl),
        .rst_vec(rst_vec), .cur_level(cur_level), .super_mode(super_mode),
        .dbl_fault(dbl_fault), .ill_ret(ill_ret), .pc_take(pc_take),
        .pc_new(pc_new)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] vec_of(int l);
        return 32'h1000 + 32'(l) * 32'h40;
    endfunction

    function automatic int lowest(logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return 16;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] m_reg(int k);
        case (k)
            0: return m_ovr;
            1: return m_mask;
            2: return m_pend;
            3: return m_lat;
            4: return m_prio;
            default: return 16'h0;
        endcase
    endfunction

    // Behavioural reference for one clock, built from the requirements
    task automatic model_step();
        int cur, cand, rl;
        bit ok, wr, go;
        logic [15:0] lclr, lset;
        cur  = lowest(m_pend & 16'hFFEE);
        cand = lowest(m_lat & m_mask);
        m_take = 0; m_dbl = 0; m_ill = 0; lclr = '0; lset = '0; go = 0; ok = 0;
        wr = reg_en && reg_we;
        if (ret_valid) begin
            case (ret_kind)
                2'd1: begin rl = 0; ok = m_pend[0]; end
                2'd2: begin rl = 2; ok = (cur == 2); end
                2'd3: begin rl = 3; ok = (cur == 3); end
                default: begin rl = cur; ok = (cur != 16 && cur != 2 && cur != 3); end
            endcase
            if (ok) begin
                if (!ret_addr[0]) m_pend[rl] = 1'b0;
                if (rl >= 5 || rl == 1) m_pend[4] = 1'b0;
                m_take = 1; m_pc = ret_addr & ~32'h1;
            end else begin
                m_ill = 1; lset[3] = 1'b1;
            end
        end else if (!wr && cand < 16) begin
            if (cand <= 1) go = 1;
            else if (cand <= 3) begin
                if (cur <= cand) begin m_dbl = 1; lclr[cand] = 1'b1; end
                else go = 1;
            end else if (cand >= 5)
                go = !m_pend[4] && (cand < cur || (nest_en && cand == cur));
        end
        if (go) begin
            m_pend[cand] = 1'b1; lclr[cand] = 1'b1;
            if (cand >= 5) m_pend[4] = 1'b1;
            m_take = 1;
            m_pc = (cand >= 7 && m_ovr[cand]) ? rst_vec : vec_of(cand);
        end
        if (wr) begin
            case (int'(reg_addr))
                0:  m_ovr  = reg_wdata[15:0];
                4:  m_mask = (reg_wdata[15:0] & 16'hFFE0) | 16'h000F;
                12: lclr   = lclr | reg_wdata[15:0];
                16: m_prio = reg_wdata[15:0] & 16'h000F;
                default: ;
            endcase
        end
        m_lat = (m_lat & ~lclr) | evt_req | lset;
    endtask

    task automatic compare_all();
        int mc;
        mc = lowest(m_pend & 16'hFFEE);
        chk("R5 cur_level", 32'(cur_level), 32'(mc));
        chk("R5 super_mode", 32'(super_mode), 32'(mc != 16));
        chk("R8 pc_take", 32'(pc_take), 32'(m_take));
        chk("R9 pc_new", pc_new, m_pc);
        chk("R7 dbl_fault", 32'(dbl_fault), 32'(m_dbl));
        chk("R11 ill_ret", 32'(ill_ret), 32'(m_ill));
        for (int k = 0; k < 6; k++) begin
            reg_addr = 5'(k * 4);
            #1;
            chk("R2 register read", reg_rdata, {16'h0, m_reg(k)});
        end
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        #1;
        cyc++;
        compare_all();
        evt_req = '0; ret_valid = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr_reg(int off, logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 5'(off); reg_wdata = d;
        cycle();
    endtask

    task automatic rd_reg(int off, string tag, logic [31:0] exp);
        reg_addr = 5'(off);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic raise(logic [15:0] r);
        evt_req = r;
        cycle();
    endtask

    task automatic do_ret(logic [1:0] k, logic [31:0] a);
        ret_valid = 1'b1; ret_kind = k; ret_addr = a;
        cycle();
    endtask

    initial begin
        for (int l = 0; l < 16; l++) vec_tbl[l*32 +: 32] = vec_of(l);
    end

    initial begin : watchdog
        forever begin
            @(posedge clk);
            if (!done && cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_ovr = '0; m_mask = 16'h000F; m_pend = 16'h0012; m_lat = '0; m_prio = '0;
        m_pc = '0; m_take = 0; m_dbl = 0; m_ill = 0;

        // R1: reset values
        chk("R1 cur_level", 32'(cur_level), 32'd1);
        chk("R1 super_mode", 32'(super_mode), 32'd1);
        rd_reg(4, "R1 mask", 32'h0000_000F);
        rd_reg(8, "R1 active", 32'h0000_0012);
        rd_reg(0, "R1 override", 32'h0);

        // R10: return from reset clears level 1 and global-disable
        do_ret(2'd0, 32'h0000_0200);
        chk("R10 return pc", pc_new, 32'h0000_0200);
        chk("R10 user after return", 32'(cur_level), 32'd16);

        // R3: mask, priority and read-only active register
        wr_reg(4, 32'hFFFF_FFFF);
        rd_reg(4, "R3 mask write", 32'h0000_FFEF);
        wr_reg(16, 32'hFFFF_FFFF);
        rd_reg(16, "R3 priority write", 32'h0000_000F);
        wr_reg(8, 32'hFFFF_FFFF);
        rd_reg(8, "R3 active ignores write", 32'h0);
        wr_reg(20, 32'hFFFF_FFFF);
        rd_reg(20, "R2 unmapped offset", 32'h0);

        // R8: take level 9
        raise(16'h0200);
        idle(1);
        chk("R8 take level 9", pc_new, vec_of(9));
        rd_reg(8, "R8 active after take", 32'h0000_0210);

        // R6: level 7 blocked by global-disable
        raise(16'h0080);
        idle(2);
        chk("R6 blocked by disable", 32'(pc_take), 32'd0);
        rd_reg(12, "R6 still latched", 32'h0000_0080);

        // R12: no arbitration in the return cycle, level 7 taken next cycle
        do_ret(2'd0, 32'h0000_0300);
        chk("R12 return wins the cycle", pc_new, 32'h0000_0300);
        idle(1);
        chk("R12 level 7 after return", pc_new, vec_of(7));
        do_ret(2'd0, 32'h0000_0400);

        // R9: override sends level 8 to the reset vector
        wr_reg(0, 32'h0000_0100);
        raise(16'h0100);
        idle(1);
        chk("R9 override vector", pc_new, 32'hFFA0_0000);
        do_ret(2'd0, 32'h0000_0500);

        // R12: simultaneous requests, lowest wins
        raise(16'h0840);
        idle(1);
        chk("R12 lowest wins", pc_new, vec_of(6));
        do_ret(2'd0, 32'h0000_0600);
        idle(1);
        chk("R12 remaining level 11", pc_new, vec_of(11));
        do_ret(2'd0, 32'h0000_0610);

        // R10 and R6: self-nested return keeps the level, re-entry with nest_en
        nest_en = 1'b1;
        raise(16'h0400);
        idle(1);
        do_ret(2'd0, 32'h0000_0701);
        chk("R10 self-nest pc", pc_new, 32'h0000_0700);
        chk("R10 level kept", 32'(cur_level), 32'd10);
        raise(16'h0400);
        idle(1);
        chk("R6 same-level nesting", pc_new, vec_of(10));
        do_ret(2'd0, 32'h0000_0710);
        nest_en = 1'b0;
        idle(1);

        // R7: repeated exception causes a double fault
        raise(16'h0008);
        idle(1);
        chk("R7 exception taken", pc_new, vec_of(3));
        raise(16'h0008);
        idle(1);
        chk("R7 double fault", 32'(dbl_fault), 32'd1);
        do_ret(2'd3, 32'h0000_0800);

        // R11: NMI return from user mode is illegal and latches level 3
        do_ret(2'd2, 32'h0000_0900);
        chk("R11 illegal return", 32'(ill_ret), 32'd1);
        idle(1);
        chk("R11 exception follows", pc_new, vec_of(3));
        do_ret(2'd3, 32'h0000_0910);

        // R4: W1C and same-cycle request priority
        wr_reg(4, 32'h0);
        raise(16'h1000);
        rd_reg(12, "R4 request latched", 32'h0000_1000);
        wr_reg(12, 32'h0000_1000);
        rd_reg(12, "R4 write-one-to-clear", 32'h0);
        evt_req = 16'h2000;
        wr_reg(12, 32'h0000_2000);
        rd_reg(12, "R4 request beats clear", 32'h0000_2000);
        wr_reg(12, 32'h0000_2000);

        // R6: level 4 never taken
        raise(16'h0010);
        idle(2);
        chk("R6 level 4 not taken", 32'(pc_take), 32'd0);
        wr_reg(12, 32'h0000_0010);

        // R7: reset level taken even with global-disable set
        wr_reg(4, 32'hFFFF);
        raise(16'h0200);
        idle(1);
        raise(16'h0002);
        idle(1);
        chk("R7 reset level preempts", pc_new, vec_of(1));
        chk("R7 current level 1", 32'(cur_level), 32'd1);
        do_ret(2'd0, 32'h0000_0A00);
        do_ret(2'd0, 32'h0000_0A10);
        idle(2);

        // Mixed stimulus against the reference model
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 5) == 0)
                evt_req = 16'(1) << $urandom_range(2, 15);
            if ($urandom_range(0, 40) == 0)
                evt_req = evt_req | (16'(1) << $urandom_range(0, 1));
            if ($urandom_range(0, 6) == 0) begin
                ret_valid = 1'b1;
                ret_kind  = 2'($urandom_range(0, 3));
                ret_addr  = $urandom;
            end else if ($urandom_range(0, 15) == 0) begin
                reg_en = 1'b1; reg_we = 1'b1;
                reg_addr = 5'($urandom_range(0, 5) * 4);
                reg_wdata = $urandom;
            end
            if ($urandom_range(0, 30) == 0) nest_en = ~nest_en;
            cycle();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule